// File: doc/BRIEF.md
# Programmed-I/O Device Interface Decoder

This block sits between a 12-bit processor's I/O instruction path and a disk controller. It watches every I/O transfer instruction. It acts only on those whose upper six bits are the fixed pattern `110 111` and whose device field, bits 5..3, equals a strapped three-bit code. The low three bits select one of seven operations:

- load a command word into the controller
- move a data word
- test-and-clear the transfer-request flag
- test-and-clear the error flag
- test-and-clear the done flag
- set the interrupt enable
- initialise

Skip, accumulator-clear and accumulator-OR strobes go back to the processor combinationally, in the same cycle as the instruction.

Towards the controller the block presents three things:

- the latched command word and a one-cycle start pulse
- an interface register with a request/acknowledge word link
- a one-cycle reset pulse

The controller reports word completion, errors and command completion with single-cycle pulses. A completion pulse also carries a status word.

A data-transfer instruction behaves in one of three ways. The choice depends on the function field and the 8-bit-mode bit of the active command. It either copies the accumulator out, ORs the interface register into the accumulator, or replaces the accumulator with the interface register.

Top module: `pio_dev_decoder`

## Requirements
- R1: An instruction is acted on only when `iot_valid_i` is high, `instr_i[11:6]` is `110111` and `instr_i[5:3]` equals `dev_sel_i`. Any other instruction changes no flag or state and raises no strobe.
- R2: Operation 1 (load command) raises `ac_clr_o` in its own cycle. When no command is active it also latches `ac_i` into `cmd_o` and pulses `cmd_start_o` for the following cycle.
- R3: A load command issued while a command is active (after a load, before `done_i`) still raises `ac_clr_o`. It leaves `cmd_o` unchanged and gives no `cmd_start_o`.
- R4: Operations 3, 4 and 5 drive `skip_o` from the transfer-request, error and done flag respectively, in the instruction cycle. Each clears its flag afterwards.
- R5: Operation 6 loads `ac_i[0]` into the interrupt enable, and `irq_o` equals enable AND (done OR error).
- R6: The transfer-request flag alone never raises `irq_o`.
- R7: `link_ack_i` during an active command sets the transfer-request flag and opens a word slot. For functions 1, 5 and 7 (function = `cmd_o[3:1]`) it also loads `link_data_i` into the interface register, which is visible on `ac_o`.
- R8: A data transfer (operation 2) into an open slot under functions 0, 2, 3, 4 or 6 copies `ac_i` to `link_data_o`. It raises `link_req_o` from the next cycle until `link_ack_i`, `done_i` or initialise, and asserts neither accumulator strobe.
- R9: A data transfer into an open slot under function 1 with `cmd_o[6]`=1, or under functions 5 or 7, asserts `ac_or_o` only. Under function 1 with `cmd_o[6]`=0 it asserts both `ac_clr_o` and `ac_or_o`.
- R10: A data transfer during an active command with no open slot is ignored. It raises no strobe, starts no request and leaves `link_data_o` unchanged.
- R11: `done_i` sets the done flag, ends the active command and loads `status_i` into the interface register. A data transfer with no active command then asserts `ac_or_o` with `ac_o` equal to that status.
- R12: `err_i` sets the error flag.
- R13: Operation 7 clears all three flags, the interrupt enable, the active command, the open slot and any pending request. It pulses `ctrl_rst_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_sel_i | input | 3 | Strapped device code |
| iot_valid_i | input | 1 | I/O instruction present this cycle |
| instr_i | input | 12 | I/O instruction word |
| ac_i | input | 12 | Accumulator value |
| skip_o | output | 1 | Skip next instruction |
| ac_clr_o | output | 1 | Clear accumulator |
| ac_or_o | output | 1 | OR `ac_o` into accumulator |
| ac_o | output | 12 | Interface register towards the processor |
| irq_o | output | 1 | Interrupt request |
| cmd_o | output | 12 | Latched command word |
| cmd_start_o | output | 1 | Command start pulse |
| link_req_o | output | 1 | Word handed to controller / next word requested |
| link_data_o | output | 12 | Interface register towards the controller |
| link_ack_i | input | 1 | Word move across the link finished |
| link_data_i | input | 12 | Word from the controller |
| done_i | input | 1 | Command completed |
| err_i | input | 1 | Error detected |
| status_i | input | 12 | Status word loaded at completion |
| ctrl_rst_o | output | 1 | Controller reset pulse |

## Verification
Several properties are checked on every cycle:

- non-matching instructions raise no strobe
- a load command always clears the accumulator, and only an accepted one produces a start pulse
- skip operations clear their flag
- the transfer-request flag alone never interrupts
- a pending link request holds until it is answered
- a transfer into a closed slot is inert

Other behaviour can only be shown by the bench's scenarios, which follow full command sequences: the choice among copy, OR and replace for each function and mode, the status readback after completion, and the full clearing effect of initialise.

// File: rtl/pio_dev_pkg.sv
package pio_dev_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LCMD = 3'd1,
    OP_XFER = 3'd2,
    OP_STR  = 3'd3,
    OP_SER  = 3'd4,
    OP_SDN  = 3'd5,
    OP_IEN  = 3'd6,
    OP_INIT = 3'd7
  } op_e;

  typedef enum logic [1:0] {ACT_LOAD, ACT_OR, ACT_REPL} act_e;

  localparam int unsigned NFLG     = 3;
  localparam int unsigned FLG_TR   = 0;
  localparam int unsigned FLG_ERR  = 1;
  localparam int unsigned FLG_DONE = 2;
  localparam int unsigned FUNC_LSB = 1;
  localparam int unsigned MODE_BIT = 6;

  function automatic logic func_to_cpu(logic [2:0] func);
    return (func == 3'd1) || (func == 3'd5) || (func == 3'd7);
  endfunction

  function automatic act_e xfer_action(logic [2:0] func, logic mode8);
    if (func == 3'd1) return mode8 ? ACT_OR : ACT_REPL;
    if (func_to_cpu(func)) return ACT_OR;
    return ACT_LOAD;
  endfunction
endpackage

// File: rtl/pio_iot_decode.sv
module pio_iot_decode
  import pio_dev_pkg::*;
#(
  parameter int unsigned W    = 12,
  parameter int unsigned DEVW = 3
) (
  input  logic            valid_i,
  input  logic [W-1:0]    instr_i,
  input  logic [DEVW-1:0] dev_sel_i,
  output logic            hit_o,
  output op_e             op_o
);
  localparam int unsigned PFX_W = 6;
  localparam logic [PFX_W-1:0] PFX = 6'b110111;
  localparam int unsigned DEV_LSB = 3;

  assign hit_o = valid_i
              && (instr_i[W-1 -: PFX_W] == PFX)
              && (instr_i[DEV_LSB +: DEVW] == dev_sel_i);
  assign op_o  = op_e'(instr_i[2:0]);
endmodule

// File: rtl/pio_flag_bank.sv
module pio_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= 1'b0;
      else if (init_i)    q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;   // new event wins over test-and-clear
      else if (clr_i[g])  q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_xfer_path.sv
module pio_xfer_path
  import pio_dev_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lcmd_i,
  input  logic         xfer_i,
  input  logic         init_i,
  input  logic [W-1:0] ac_i,
  input  logic         link_ack_i,
  input  logic [W-1:0] link_data_i,
  input  logic         done_i,
  input  logic [W-1:0] status_i,
  output logic         busy_o,
  output logic         slot_o,
  output logic         take_o,
  output act_e         act_o,
  output logic [W-1:0] cmd_o,
  output logic         cmd_start_o,
  output logic [W-1:0] ireg_o,
  output logic         link_req_o,
  output logic         ctrl_rst_o
);
  logic [2:0] func;
  logic       to_cpu;

  assign func   = cmd_o[FUNC_LSB +: 3];
  assign to_cpu = func_to_cpu(func);
  assign act_o  = xfer_action(func, cmd_o[MODE_BIT]);
  assign take_o = xfer_i && busy_o && slot_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o      <= 1'b0;
      slot_o      <= 1'b0;
      cmd_o       <= '0;
      cmd_start_o <= 1'b0;
      ireg_o      <= '0;
      link_req_o  <= 1'b0;
      ctrl_rst_o  <= 1'b0;
    end else begin
      cmd_start_o <= 1'b0;
      ctrl_rst_o  <= init_i;
      if (init_i) begin
        busy_o     <= 1'b0;
        slot_o     <= 1'b0;
        link_req_o <= 1'b0;
      end else if (done_i) begin
        busy_o     <= 1'b0;
        slot_o     <= 1'b0;
        link_req_o <= 1'b0;
        ireg_o     <= status_i;
      end else if (lcmd_i && !busy_o) begin
        cmd_o       <= ac_i;
        busy_o      <= 1'b1;
        slot_o      <= 1'b0;
        link_req_o  <= 1'b0;
        cmd_start_o <= 1'b1;
      end else if (busy_o) begin
        if (link_ack_i) begin
          slot_o     <= 1'b1;
          link_req_o <= 1'b0;
          if (to_cpu) ireg_o <= link_data_i;
        end else if (take_o) begin
          slot_o     <= 1'b0;
          link_req_o <= 1'b1;
          if (act_o == ACT_LOAD) ireg_o <= ac_i;
        end
      end
    end
  end
endmodule

// File: rtl/pio_dev_decoder.sv
module pio_dev_decoder
  import pio_dev_pkg::*;
#(
  parameter int unsigned W    = 12,
  parameter int unsigned DEVW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DEVW-1:0] dev_sel_i,
  input  logic            iot_valid_i,
  input  logic [W-1:0]    instr_i,
  input  logic [W-1:0]    ac_i,
  output logic            skip_o,
  output logic            ac_clr_o,
  output logic            ac_or_o,
  output logic [W-1:0]    ac_o,
  output logic            irq_o,
  output logic [W-1:0]    cmd_o,
  output logic            cmd_start_o,
  output logic            link_req_o,
  output logic [W-1:0]    link_data_o,
  input  logic            link_ack_i,
  input  logic [W-1:0]    link_data_i,
  input  logic            done_i,
  input  logic            err_i,
  input  logic [W-1:0]    status_i,
  output logic            ctrl_rst_o
);
  logic            iot_hit;
  op_e             iot_op;
  logic            op_lcmd, op_xfer, op_init;
  logic [NFLG-1:0] flg_q, flg_set, flg_clr;
  logic            ie_q;
  logic            busy_q, slot_q, take;
  act_e            act;
  logic [W-1:0]    ireg_q;

  pio_iot_decode #(.W(W), .DEVW(DEVW)) u_dec (
    .valid_i   (iot_valid_i),
    .instr_i   (instr_i),
    .dev_sel_i (dev_sel_i),
    .hit_o     (iot_hit),
    .op_o      (iot_op)
  );

  assign op_lcmd = iot_hit && (iot_op == OP_LCMD);
  assign op_xfer = iot_hit && (iot_op == OP_XFER);
  assign op_init = iot_hit && (iot_op == OP_INIT);

  assign flg_set[FLG_TR]   = link_ack_i && busy_q;
  assign flg_set[FLG_ERR]  = err_i;
  assign flg_set[FLG_DONE] = done_i;
  assign flg_clr[FLG_TR]   = iot_hit && (iot_op == OP_STR);
  assign flg_clr[FLG_ERR]  = iot_hit && (iot_op == OP_SER);
  assign flg_clr[FLG_DONE] = iot_hit && (iot_op == OP_SDN);

  pio_flag_bank #(.N(NFLG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (op_init),
    .set_i  (flg_set),
    .clr_i  (flg_clr),
    .q_o    (flg_q)
  );

  pio_xfer_path #(.W(W)) u_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lcmd_i      (op_lcmd),
    .xfer_i      (op_xfer),
    .init_i      (op_init),
    .ac_i        (ac_i),
    .link_ack_i  (link_ack_i),
    .link_data_i (link_data_i),
    .done_i      (done_i),
    .status_i    (status_i),
    .busy_o      (busy_q),
    .slot_o      (slot_q),
    .take_o      (take),
    .act_o       (act),
    .cmd_o       (cmd_o),
    .cmd_start_o (cmd_start_o),
    .ireg_o      (ireg_q),
    .link_req_o  (link_req_o),
    .ctrl_rst_o  (ctrl_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ie_q <= 1'b0;
    else if (op_init)                         ie_q <= 1'b0;
    else if (iot_hit && (iot_op == OP_IEN))   ie_q <= ac_i[0];
  end

  assign skip_o   = |(flg_clr & flg_q);
  assign ac_clr_o = op_lcmd || (take && (act == ACT_REPL));
  // idle transfer reads back status; active transfer reads only into an open slot
  assign ac_or_o  = op_xfer && (!busy_q || (slot_q && (act != ACT_LOAD)));
  assign ac_o        = ireg_q;
  assign link_data_o = ireg_q;
  assign irq_o    = ie_q && (flg_q[FLG_DONE] || flg_q[FLG_ERR]);
endmodule

// File: rtl/pio_dev_decoder_chk.sv
module pio_dev_decoder_chk #(
  parameter int unsigned W    = 12,
  parameter int unsigned DEVW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DEVW-1:0] dev_sel_i,
  input logic            iot_valid_i,
  input logic [W-1:0]    instr_i,
  input logic            skip_o,
  input logic            ac_clr_o,
  input logic            ac_or_o,
  input logic            irq_o,
  input logic [W-1:0]    cmd_o,
  input logic            cmd_start_o,
  input logic            link_req_o,
  input logic [W-1:0]    link_data_o,
  input logic            link_ack_i,
  input logic            done_i,
  input logic            ctrl_rst_o,
  input logic            busy_q,
  input logic            slot_q,
  input logic            tr_q,
  input logic            err_q,
  input logic            done_q
);
  logic match, is_lcmd, is_xfer, is_str, is_init;
  assign match   = iot_valid_i && (instr_i[W-1 -: 6] == 6'b110111) && (instr_i[5:3] == dev_sel_i);
  assign is_lcmd = match && (instr_i[2:0] == 3'd1);
  assign is_xfer = match && (instr_i[2:0] == 3'd2);
  assign is_str  = match && (instr_i[2:0] == 3'd3);
  assign is_init = match && (instr_i[2:0] == 3'd7);

  p_nomatch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iot_valid_i && !match) |-> (!skip_o && !ac_clr_o && !ac_or_o));
  p_lcmd_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lcmd |-> ac_clr_o);
  p_start_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |-> $past(is_lcmd));
  p_busy_lcmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_lcmd && busy_q && !done_i && !is_init) |=> (!cmd_start_o && $stable(cmd_o)));
  p_str_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_str && !link_ack_i) |=> !tr_q);
  p_tr_no_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_q && !err_q) |-> !irq_o);
  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && !link_ack_i && !done_i && !is_init) |=> link_req_o);
  p_closed_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_xfer && busy_q && !slot_q && !link_ack_i && !done_i)
      |-> (!ac_or_o && !ac_clr_o));
  p_closed_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_xfer && busy_q && !slot_q && !link_ack_i && !done_i && !link_req_o)
      |=> (!link_req_o && $stable(link_data_o)));
  p_init_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_init |=> (ctrl_rst_o && !irq_o && !link_req_o));
endmodule

bind pio_dev_decoder pio_dev_decoder_chk #(.W(W), .DEVW(DEVW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_sel_i   (dev_sel_i),
  .iot_valid_i (iot_valid_i),
  .instr_i     (instr_i),
  .skip_o      (skip_o),
  .ac_clr_o    (ac_clr_o),
  .ac_or_o     (ac_or_o),
  .irq_o       (irq_o),
  .cmd_o       (cmd_o),
  .cmd_start_o (cmd_start_o),
  .link_req_o  (link_req_o),
  .link_data_o (link_data_o),
  .link_ack_i  (link_ack_i),
  .done_i      (done_i),
  .ctrl_rst_o  (ctrl_rst_o),
  .busy_q      (busy_q),
  .slot_q      (slot_q),
  .tr_q        (flg_q[0]),
  .err_q       (flg_q[1]),
  .done_q      (flg_q[2])
);

// File: tb/pio_dev_decoder_tb.sv
`timescale 1ns/1ps
module pio_dev_decoder_tb;
  localparam int W = 12;
  localparam logic [2:0] DEV = 3'd5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] dev_sel_i = DEV;
  logic iot_valid_i = 1'b0;
  logic [W-1:0] instr_i = '0, ac_i = '0;
  logic skip_o, ac_clr_o, ac_or_o, irq_o, cmd_start_o, link_req_o, ctrl_rst_o;
  logic [W-1:0] ac_o, cmd_o, link_data_o;
  logic link_ack_i = 1'b0, done_i = 1'b0, err_i = 1'b0;
  logic [W-1:0] link_data_i = '0, status_i = '0;

  int n_chk = 0, n_err = 0;
  logic s_skip, s_clr, s_or;
  logic [W-1:0] s_ac;

  always #4 clk = ~clk;

  pio_dev_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dev_sel_i(dev_sel_i), .iot_valid_i(iot_valid_i),
    .instr_i(instr_i), .ac_i(ac_i), .skip_o(skip_o), .ac_clr_o(ac_clr_o),
    .ac_or_o(ac_or_o), .ac_o(ac_o), .irq_o(irq_o), .cmd_o(cmd_o),
    .cmd_start_o(cmd_start_o), .link_req_o(link_req_o), .link_data_o(link_data_o),
    .link_ack_i(link_ack_i), .link_data_i(link_data_i), .done_i(done_i),
    .err_i(err_i), .status_i(status_i), .ctrl_rst_o(ctrl_rst_o)
  );

  // 0 copy out, 1 OR in, 2 replace
  function automatic int exp_act(logic [2:0] func, logic mode8);
    if (func == 3'd1) return mode8 ? 1 : 2;
    if (func == 3'd5 || func == 3'd7) return 1;
    return 0;
  endfunction

  task automatic chk(string rq, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic iot_raw(logic [W-1:0] ins, logic [W-1:0] ac);
    @(negedge clk);
    iot_valid_i = 1'b1; instr_i = ins; ac_i = ac;
    #2;
    s_skip = skip_o; s_clr = ac_clr_o; s_or = ac_or_o; s_ac = ac_o;
    @(negedge clk);
    iot_valid_i = 1'b0;
  endtask

  task automatic iot(logic [2:0] op, logic [W-1:0] ac);
    iot_raw({6'b110111, DEV, op}, ac);
  endtask

  task automatic ack(logic [W-1:0] d);
    @(negedge clk); link_ack_i = 1'b1; link_data_i = d;
    @(negedge clk); link_ack_i = 1'b0;
  endtask

  task automatic fin(logic [W-1:0] s);
    @(negedge clk); done_i = 1'b1; status_i = s;
    @(negedge clk); done_i = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); err_i = 1'b1;
    @(negedge clk); err_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    chk("R4 reset irq", {11'd0, irq_o}, 12'd0);
    chk("R2 reset cmd", cmd_o, 12'd0);
    iot(3'd3, 0); chk("R4 reset tr skip", {11'd0, s_skip}, 12'd0);
    iot(3'd5, 0); chk("R4 reset done skip", {11'd0, s_skip}, 12'd0);

    // R12 / R1 / R4
    pulse_err();
    iot_raw({6'b110111, 3'd6, 3'd4}, 0);
    chk("R1 other dev no skip", {11'd0, s_skip}, 12'd0);
    iot_raw({6'b110110, DEV, 3'd4}, 0);
    chk("R1 bad prefix no skip", {11'd0, s_skip}, 12'd0);
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] ins;
      ins = W'($urandom);
      if (ins[11:3] == {6'b110111, DEV}) ins[3] = ~ins[3];
      iot_raw(ins, W'($urandom));
      chk("R1 random nonmatch strobes", {9'd0, s_skip, s_clr, s_or}, 12'd0);
    end
    iot(3'd4, 0); chk("R12 err set skip", {11'd0, s_skip}, 12'd1);
    iot(3'd4, 0); chk("R4 err cleared", {11'd0, s_skip}, 12'd0);

    // R5 interrupt enable
    iot(3'd6, 12'd1);
    chk("R5 ie no flag", {11'd0, irq_o}, 12'd0);
    pulse_err();
    chk("R5 irq on err", {11'd0, irq_o}, 12'd1);
    iot(3'd4, 0);
    chk("R5 irq drops", {11'd0, irq_o}, 12'd0);

    // fill, 12-bit mode: function 0
    iot(3'd1, 12'o0000);
    chk("R2 lcmd clr", {11'd0, s_clr}, 12'd1);
    chk("R2 start pulse", {11'd0, cmd_start_o}, 12'd1);
    ack(12'h999);
    chk("R6 tr no irq", {11'd0, irq_o}, 12'd0);
    chk("R7 fill ack keeps ireg", link_data_o, 12'd0);
    iot(3'd3, 0); chk("R4 tr skip", {11'd0, s_skip}, 12'd1);
    iot(3'd2, 12'h5A3);
    chk("R8 load no strobes", {10'd0, s_clr, s_or}, 12'd0);
    chk("R8 link data", link_data_o, 12'h5A3);
    chk("R8 link req", {11'd0, link_req_o}, 12'd1);
    iot(3'd2, 12'h111);
    chk("R10 closed strobes", {10'd0, s_clr, s_or}, 12'd0);
    chk("R10 closed data", link_data_o, 12'h5A3);
    chk("R10 req still pending", {11'd0, link_req_o}, 12'd1);
    ack(12'h0);
    chk("R8 req cleared by ack", {11'd0, link_req_o}, 12'd0);
    iot(3'd1, 12'o0252);
    chk("R3 busy lcmd clr", {11'd0, s_clr}, 12'd1);
    chk("R3 busy no start", {11'd0, cmd_start_o}, 12'd0);
    chk("R3 busy cmd kept", cmd_o, 12'o0000);
    fin(12'h0C4);
    chk("R11 irq on done", {11'd0, irq_o}, 12'd1);
    iot(3'd5, 0); chk("R11 done skip", {11'd0, s_skip}, 12'd1);
    iot(3'd2, 12'h000);
    chk("R11 idle or", {10'd0, s_clr, s_or}, 12'd1);
    chk("R11 status readback", s_ac, 12'h0C4);

    // empty 12-bit: replace
    iot(3'd1, 12'o0002);
    ack(12'h7E1);
    iot(3'd2, 0);
    chk("R9 empty12 replace", {10'd0, s_clr, s_or}, 12'd3);
    chk("R7 empty12 data", s_ac, 12'h7E1);
    fin(12'h000);
    // empty 8-bit: OR
    iot(3'd1, 12'o0102);
    ack(12'h0F5);
    iot(3'd2, 0);
    chk("R9 empty8 or", {10'd0, s_clr, s_or}, 12'd1);
    chk("R7 empty8 data", s_ac, 12'h0F5);
    fin(12'h000);

    // random command sequences
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] c, d, a, s;
      int ea;
      c = W'($urandom); d = W'($urandom); a = W'($urandom); s = W'($urandom);
      ea = exp_act(c[3:1], c[6]);
      iot(3'd1, c);
      chk("R2 random cmd", cmd_o, c);
      ack(d);
      iot(3'd2, a);
      if (ea == 0) begin
        chk("R8 random copy strobes", {10'd0, s_clr, s_or}, 12'd0);
        chk("R8 random copy data", link_data_o, a);
      end else begin
        chk("R9 random strobes", {10'd0, s_clr, s_or}, (ea == 2) ? 12'd3 : 12'd1);
        chk("R7 random data", s_ac, d);
      end
      fin(s);
      chk("R11 random req cleared", {11'd0, link_req_o}, 12'd0);
      iot(3'd5, 0); chk("R11 random done skip", {11'd0, s_skip}, 12'd1);
      iot(3'd2, 0); chk("R11 random status", s_ac, s);
    end

    // R13 initialise
    iot(3'd1, 12'o0000);
    ack(12'h0);
    pulse_err();
    iot(3'd2, 12'h3C3);
    chk("R13 pre req", {11'd0, link_req_o}, 12'd1);
    iot(3'd7, 0);
    chk("R13 ctrl reset", {11'd0, ctrl_rst_o}, 12'd1);
    chk("R13 req cleared", {11'd0, link_req_o}, 12'd0);
    chk("R13 irq low", {11'd0, irq_o}, 12'd0);
    chk("R13 reset one cycle", {11'd0, ctrl_rst_o}, 12'd1);
    @(negedge clk);
    chk("R13 reset pulse ends", {11'd0, ctrl_rst_o}, 12'd0);
    iot(3'd3, 0); chk("R13 tr cleared", {11'd0, s_skip}, 12'd0);
    iot(3'd4, 0); chk("R13 err cleared", {11'd0, s_skip}, 12'd0);
    pulse_err();
    chk("R13 ie cleared", {11'd0, irq_o}, 12'd0);
    iot(3'd1, 12'o0016);
    chk("R13 not busy after init", {11'd0, cmd_start_o}, 12'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule